// File: doc/BRIEF.md
# Serial interrupt status controller

This block manages the interrupts of a peripheral that a host reaches over a four-wire serial port. It has an 8-bit flag register and an 8-bit mask register, with one bit per interrupt source. Single-cycle event pulses from the rest of the device set the flags whether or not they are masked. Any flag whose mask bit is set pulls the active-low request line `irq_n` low.

The host services the line with a read that clears the flags. While that read is in progress, the request line stays released from the end of the command byte until the end of the returned data byte. Events that arrive during that window are kept and show up in the flags afterwards. If one of them is enabled, the request line drops again once the byte is done. A plain flag read that leaves everything as it was, and read/write access to the mask, complete the register set.

The serial pins are sampled by the system clock through synchronizers. The serial clock therefore has to be several times slower than the system clock.

Top module: `irq_serial_ctrl`

## Requirements
- R1: After reset the flags and the mask are zero, `irq_n` is 1 and `sdo` is 0. A read of either register returns 00h.
- R2: A one-cycle pulse on bit i of `evt` sets flag i, whatever the value of mask bit i.
- R3: `irq_n` is 0 exactly when some flag and its mask bit are both 1, except during the hold window of R7. A masked flag leaves `irq_n` at 1.
- R4: Writing the mask uses command byte 8Ah (bit 7 = 1 marks a write, bits 6:0 hold address 0Ah), followed by the data byte. Reading the mask uses 0Ah with bit 7 = 0. A write to any other address changes nothing.
- R5: A read at address 04h returns the flags and changes neither the flags nor `irq_n`.
- R6: A read at address 05h returns the flags as they were at the end of the command byte. After the data byte it leaves zero in every flag that no new event has set.
- R7: During a completed 05h read, `irq_n` is 1 from the last falling SCLK edge of the command byte until the last falling edge of the data byte.
- R8: An event that arrives during a 05h read is kept in the flags, even when its flag was already set and has just been read. If it is enabled, `irq_n` returns to 0 after the data byte.
- R9: Raising `cs_n` in the middle of a frame aborts it. An aborted 05h read leaves the flags unchanged and ends the hold of R7. An aborted write leaves the mask unchanged.
- R10: A read at an address that has no register returns 00h.
- R11: Frame format: an 8-bit command byte then an 8-bit data byte, both MSB first. `sdi` is sampled on falling SCLK edges and `sdo` changes on rising SCLK edges, starting with the rising edge after the command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle high |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| evt | input | 8 | Single-cycle event pulses, one per source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is an event pulse that lands inside a clearing read. That means after the command byte has been taken in, but before the last data bit has gone out. The bench's frame driver can pulse `evt` at a chosen bit position of the frame. It uses this both for a source whose flag was already set and has just been read, and for a masked one. The same driver can also stop a frame part-way through the data byte, which exercises the abort path for a clearing read and for a mask write. The result is then read back with the plain flag read.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  // Access selected by the command byte, latched for the data byte
  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_RD_STAT = 3'd1,
    K_RD_CLR  = 3'd2,
    K_RD_MASK = 3'd3,
    K_WR_MASK = 3'd4
  } irqs_kind_e;

endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q = st_q[STAGES-1];

endmodule

// File: rtl/irqs_serial.sv
module irqs_serial #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] tx_data,
  output logic          frame_act,
  output logic          cmd_done,
  output logic          data_done,
  output logic [AW:0]   cmd_word,
  output logic [DW-1:0] data_word,
  output logic          sdo
);

  localparam int unsigned CW    = AW + 1;
  localparam int unsigned FRAME = CW + DW;
  localparam int unsigned RW    = (DW > CW) ? DW : CW;
  localparam int unsigned NW    = $clog2(FRAME + 1);

  logic          sclk_q;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [RW-2:0] rx_q, rx_d;
  logic [RW-1:0] rx_nx;
  logic [DW-1:0] tx_q, tx_d;
  logic          sdo_d;
  logic          fall, rise, in_data;

  always_comb begin
    fall      = sclk_q & ~sclk_s;
    rise      = ~sclk_q & sclk_s;
    frame_act = ~cs_s;
    rx_nx     = {rx_q, sdi_s};
    cmd_word  = rx_nx[AW:0];
    data_word = rx_nx[DW-1:0];
    cmd_done  = frame_act & fall & (cnt_q == NW'(CW - 1));
    data_done = frame_act & fall & (cnt_q == NW'(FRAME - 1));
    in_data   = (cnt_q >= NW'(CW)) && (cnt_q < NW'(FRAME));

    cnt_d = cnt_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    sdo_d = sdo;
    if (!frame_act) begin
      cnt_d = '0;
      tx_d  = '0;
      sdo_d = 1'b0;
    end else begin
      if (fall && (cnt_q < NW'(FRAME))) begin
        cnt_d = cnt_q + 1'b1;
        rx_d  = rx_nx[RW-2:0];
      end
      if (cmd_done) tx_d = tx_data;
      if (rise && in_data) begin
        sdo_d = tx_q[DW-1];
        tx_d  = {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      sdo    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      sdo    <= sdo_d;
    end
  end

endmodule

// File: rtl/irqs_regs.sv
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 7,
  parameter int unsigned A_STAT = 4,
  parameter int unsigned A_CLR  = 5,
  parameter int unsigned A_MASK = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          frame_act,
  input  logic          cmd_done,
  input  logic          data_done,
  input  logic [AW:0]   cmd_word,
  input  logic [DW-1:0] data_word,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] en_q,
  output logic          hold_q,
  output logic          irq_n
);

  irqs_kind_e    kind_now, kind_q, kind_d;
  logic [DW-1:0] stat_d, en_d, pend_q, pend_d;
  logic          hold_d, irq_d;
  logic [AW-1:0] addr;
  logic          is_wr;

  // Decode of the command byte as it completes
  always_comb begin
    is_wr = cmd_word[AW];
    addr  = cmd_word[AW-1:0];
    if (is_wr) begin
      kind_now = (addr == AW'(A_MASK)) ? K_WR_MASK : K_NONE;
    end else if (addr == AW'(A_STAT)) begin
      kind_now = K_RD_STAT;
    end else if (addr == AW'(A_CLR)) begin
      kind_now = K_RD_CLR;
    end else if (addr == AW'(A_MASK)) begin
      kind_now = K_RD_MASK;
    end else begin
      kind_now = K_NONE;
    end
    case (kind_now)
      K_RD_STAT, K_RD_CLR: tx_data = stat_q;
      K_RD_MASK:           tx_data = en_q;
      default:             tx_data = '0;
    endcase
  end

  // Flags always collect events; during a clearing read a second
  // accumulator keeps what arrived since the snapshot.
  always_comb begin
    stat_d = stat_q | evt;
    pend_d = pend_q | evt;
    en_d   = en_q;
    hold_d = hold_q;
    kind_d = kind_q;
    if (!frame_act) begin
      hold_d = 1'b0;
      pend_d = '0;
      kind_d = K_NONE;
    end else if (cmd_done) begin
      kind_d = kind_now;
      if (kind_now == K_RD_CLR) begin
        hold_d = 1'b1;
        pend_d = evt;
      end
    end else if (data_done) begin
      kind_d = K_NONE;
      if (kind_q == K_WR_MASK) en_d = data_word;
      if (kind_q == K_RD_CLR && hold_q) begin
        stat_d = pend_q | evt;
        pend_d = '0;
        hold_d = 1'b0;
      end
    end
    irq_d = hold_d | ~(|(stat_d & en_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
      hold_q <= 1'b0;
      kind_q <= K_NONE;
      irq_n  <= 1'b1;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      hold_q <= hold_d;
      kind_q <= kind_d;
      irq_n  <= irq_d;
    end
  end

endmodule

// File: rtl/irq_serial_ctrl.sv
module irq_serial_ctrl #(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 7,
  parameter int unsigned SYNC   = 2,
  parameter int unsigned A_STAT = 4,
  parameter int unsigned A_CLR  = 5,
  parameter int unsigned A_MASK = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  input  logic [DW-1:0] evt,
  output logic          irq_n
);

  logic          rst_sync_n;
  logic [2:0]    pins_s;
  logic          frame_act, cmd_done, data_done;
  logic [AW:0]   cmd_word;
  logic [DW-1:0] data_word, tx_data, stat_q, en_q;
  logic          hold_q;

  irqs_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  // {chip select, serial clock, serial data}, idle as high, high, low
  irqs_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b110)) u_pins (
    .clk(clk), .rst_n(rst_sync_n), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  irqs_serial #(.DW(DW), .AW(AW)) u_ser (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .tx_data(tx_data), .frame_act(frame_act), .cmd_done(cmd_done),
    .data_done(data_done), .cmd_word(cmd_word), .data_word(data_word),
    .sdo(sdo)
  );

  irqs_regs #(.DW(DW), .AW(AW), .A_STAT(A_STAT), .A_CLR(A_CLR),
              .A_MASK(A_MASK)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .frame_act(frame_act),
    .cmd_done(cmd_done), .data_done(data_done), .cmd_word(cmd_word),
    .data_word(data_word), .tx_data(tx_data), .stat_q(stat_q),
    .en_q(en_q), .hold_q(hold_q), .irq_n(irq_n)
  );

endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic [DW-1:0] evt,
  input logic [DW-1:0] stat,
  input logic [DW-1:0] en,
  input logic          hold,
  input logic          irq_n
);

  // R1: while reset is applied the registers are clear and the line is idle
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (irq_n && stat == '0 && en == '0);
    end
  end

  // R2: every pulsed source shows up in the flags one cycle later
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R3: with no enabled flag the request line is released
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) == '0) |-> irq_n);

  // R7: entering the hold window releases the request line
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> irq_n);

  // R9: chip select high for long enough ends any hold
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !hold);

endmodule

bind irq_serial_ctrl irqs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .evt(evt),
  .stat(stat_q), .en(en_q), .hold(hold_q), .irq_n(irq_n)
);

// File: tb/sim_irq_serial_ctrl.sv
module sim_irq_serial_ctrl;

  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b1;
  logic       sdi = 1'b0;
  logic [7:0] evt = 8'h00;
  logic       sdo, irq_n;

  int total = 0;
  int bad = 0;
  logic mid_irq = 1'b0;

  logic [7:0] exp_val[$];
  string      exp_tag[$];

  always #(CLK_P/2) clk = ~clk;

  irq_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .evt(evt), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Monitor: snoops the serial lines and scores each completed read (R11)
  int         mon_cnt = 0;
  logic [7:0] mon_cmd = 8'h00;
  logic [7:0] mon_rd  = 8'h00;
  always @(posedge cs_n) mon_cnt = 0;
  always @(negedge sclk) begin
    if (!cs_n) begin
      mon_cnt++;
      if (mon_cnt <= 8) mon_cmd = {mon_cmd[6:0], sdi};
      else              mon_rd  = {mon_rd[6:0], sdo};
      if (mon_cnt == 16 && !mon_cmd[7]) begin
        if (exp_val.size() == 0) begin
          total++; bad++;
          $display("FAIL R11: unexpected read %02h got %02h expected none", mon_cmd, mon_rd);
        end else begin
          chk(exp_tag.pop_front(), mon_rd, exp_val.pop_front());
        end
      end
    end
  end

  task automatic frame(input logic [7:0] c, input logic [7:0] d, input int nbits,
                       input int inj_bit, input logic [7:0] inj);
    logic [15:0] w;
    w = {c, d};
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sdi = w[15-b];
      if (b == inj_bit) begin
        evt = inj;
        @(negedge clk) evt = 8'h00;
        repeat (HALF-1) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (b == 12) mid_irq = irq_n;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    exp_val.push_back(e);
    exp_tag.push_back(tag);
    frame({1'b0, a}, 8'h00, 16, -1, 8'h00);
  endtask

  task automatic rdc(input logic [7:0] e, input string tag, input int ib, input logic [7:0] iv);
    exp_val.push_back(e);
    exp_tag.push_back(tag);
    frame(8'h05, 8'h00, 16, ib, iv);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    frame({1'b1, a}, d, 16, -1, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk) evt = v;
    @(negedge clk) evt = 8'h00;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R1 sdo after reset", {7'd0, sdo}, 8'h00);
    rd(7'h04, 8'h00, "R1 flags after reset");
    rd(7'h0A, 8'h00, "R1 mask after reset");

    pulse(8'h21);
    chk("R3 masked flag keeps irq high", {7'd0, irq_n}, 8'h01);
    rd(7'h04, 8'h21, "R2 flags set while masked");
    chk("R5 plain read keeps irq", {7'd0, irq_n}, 8'h01);

    wr(7'h0A, 8'h01);
    chk("R3 enabled flag drives irq", {7'd0, irq_n}, 8'h00);
    rd(7'h0A, 8'h01, "R4 mask readback");
    wr(7'h04, 8'hFF);
    rd(7'h04, 8'h21, "R4 write to flag address ignored");
    chk("R5 irq unchanged by plain read", {7'd0, irq_n}, 8'h00);
    rd(7'h13, 8'h00, "R10 unused address");

    rdc(8'h21, "R6 clear read data", -1, 8'h00);
    chk("R7 irq held high mid data byte", {7'd0, mid_irq}, 8'h01);
    chk("R6 irq released after clear", {7'd0, irq_n}, 8'h01);
    rd(7'h04, 8'h00, "R6 flags cleared");

    pulse(8'h03);
    chk("R3 irq low on new flag", {7'd0, irq_n}, 8'h00);
    rdc(8'h03, "R6 clear read data 2", 10, 8'h01);
    chk("R7 irq held with event inside", {7'd0, mid_irq}, 8'h01);
    chk("R8 irq low again after byte", {7'd0, irq_n}, 8'h00);
    rd(7'h04, 8'h01, "R8 event kept through clear");
    rdc(8'h01, "R6 clear read data 3", -1, 8'h00);
    chk("R6 irq high after final clear", {7'd0, irq_n}, 8'h01);

    pulse(8'h02);
    chk("R3 masked bit keeps irq high", {7'd0, irq_n}, 8'h01);
    rdc(8'h02, "R6 clear read data 4", 12, 8'h80);
    chk("R8 masked late event leaves irq high", {7'd0, irq_n}, 8'h01);
    rd(7'h04, 8'h80, "R8 masked late event kept");

    wr(7'h0A, 8'hFF);
    chk("R3 irq low with full mask", {7'd0, irq_n}, 8'h00);
    frame(8'h05, 8'h00, 11, -1, 8'h00);
    chk("R9 irq back low after abort", {7'd0, irq_n}, 8'h00);
    rd(7'h04, 8'h80, "R9 aborted clear keeps flags");
    frame(8'h8A, 8'h00, 12, -1, 8'h00);
    rd(7'h0A, 8'hFF, "R9 aborted write keeps mask");

    rdc(8'h80, "R6 clear read data 5", -1, 8'h00);
    chk("R6 irq high at end", {7'd0, irq_n}, 8'h01);

    if (exp_val.size() != 0) begin
      total++; bad++;
      $display("FAIL R11: got %0d unscored reads expected 0", exp_val.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule